// File: doc/BRIEF.md
# Zero-Crossing and Sag Detector

This block watches a stream of signed voltage samples and reports two things about the waveform. First, it finds where the waveform crosses zero. A hysteresis band around zero keeps noise from producing false crossings. Each crossing of the selected polarity produces a fixed-width pulse on a zero-crossing output and sets a sticky status bit.

Second, it checks whether the waveform has stayed small for a whole line period. A window opens at a crossing and closes at the next crossing of the same polarity. If every sample in that window has a magnitude below a programmable 16-bit threshold, the block declares a voltage sag. A sag raises a fatal-warning output and sets a second sticky status bit. The interrupt output is the OR of the status bits, and software clears each bit with its own clear strobe.

The sample input is a valid/ready stream. Ready is always high, so the block never applies back-pressure: every clock edge with valid high consumes one sample. The mode, threshold and clear inputs are plain control pins.

Top module: `zcs_detector`

## Requirements
- R1: `smp_ready` is high at all times after reset, and a sample is consumed on every clock edge where `smp_valid` is high.
- R2: A sample >= +HYST (default 64) sets the tracked polarity to positive. A sample <= -HYST sets it to negative. A sample strictly inside the band leaves the polarity unchanged. The first out-of-band sample after reset only establishes the polarity and is not a crossing.
- R3: A positive crossing is a change of the tracked polarity from negative to positive. A negative crossing is the reverse change.
- R4: `zx_mode` selects which crossings are reported: 2'b00 positive only, 2'b01 negative only, 2'b10 both, and 2'b11 (reserved) both.
- R5: Each reported crossing drives `zx_out` high for exactly PULSE_W (default 4) cycles, starting in the cycle after the clock edge that consumed the sample. A new crossing during the pulse restarts the count.
- R6: A sag window opens at a crossing and closes at the next crossing of the same polarity. A sag is declared at the closing crossing if every sample in the window, including the two crossing samples, has a magnitude strictly below `sag_thr`.
- R7: Any sample in a window with a magnitude >= `sag_thr` cancels the sag for that window. The next window starts at its closing crossing.
- R8: `sag_warn` rises on the edge that declares a sag. It stays high until a sample arrives with a magnitude >= `sag_thr`.
- R9: `status[0]` records sags and `status[1]` records reported crossings. Each bit is sticky. A high `sts_clr[i]` clears bit i unless a new event for that bit arrives in the same cycle, in which case the event wins.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: During and after reset, `zx_out`, `sag_warn`, `status` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready; always high |
| smp_data | input | DW (16) | Signed voltage sample |
| zx_mode | input | 2 | Crossing selection mode |
| sag_thr | input | DW (16) | Unsigned sag magnitude threshold |
| sts_clr | input | 2 | Per-bit clear strobes for the status bits |
| zx_out | output | 1 | Zero-crossing pulse |
| sag_warn | output | 1 | Fatal sag warning |
| status | output | 2 | Sticky status bits: {crossing, sag} |
| irq | output | 1 | Interrupt; OR of the status bits |

## Verification
Slow ramps that dwell inside the hysteresis band and then step out of it separate a correct band from a plain sign test. Running one waveform under all four mode codes, and counting the pulses, separates the polarity filters from one another. Reduced-amplitude waves at a fixed threshold show that a sag appears after exactly one full period. The same waves with a single large spike inside a window, or with peaks equal to the threshold, must produce no sag for that window. Randomized triangle waves with noise, gaps in `valid`, mode changes and random clears are compared against a bench model cycle by cycle, which also exercises the retrigger and set-wins-over-clear cases.

// File: rtl/zcs_pkg.sv
package zcs_pkg;
  typedef enum logic [1:0] {
    ZX_POS = 2'b00,
    ZX_NEG = 2'b01,
    ZX_ALL = 2'b10,
    ZX_RSV = 2'b11
  } zx_mode_e;

  localparam int ST_SAG = 0;
  localparam int ST_ZX  = 1;
  localparam int ST_W   = 2;
endpackage

// File: rtl/zcs_edge.sv
// Polarity tracker with hysteresis; flags crossings combinationally.
module zcs_edge #(
  parameter int DW   = 16,
  parameter int HYST = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [DW-1:0] sample,
  output logic                 pos_x,
  output logic                 neg_x
);
  localparam logic signed [DW-1:0] HI_LVL = HYST[DW-1:0];
  localparam logic signed [DW-1:0] LO_LVL = -HI_LVL;

  logic known_q, pos_q;
  logic hi, lo;

  always_comb begin
    hi    = sample >= HI_LVL;
    lo    = sample <= LO_LVL;
    pos_x = vld & known_q & ~pos_q & hi;
    neg_x = vld & known_q & pos_q & ~hi & lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known_q <= 1'b0;
      pos_q   <= 1'b0;
    end else if (vld) begin
      if (hi) begin
        known_q <= 1'b1;
        pos_q   <= 1'b1;
      end else if (lo) begin
        known_q <= 1'b1;
        pos_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zcs_sag.sv
// Full-period sag window tracking and warning level.
module zcs_sag #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [DW-1:0] sample,
  input  logic        [DW-1:0] thr,
  input  logic                 pos_x,
  input  logic                 neg_x,
  output logic                 sag_hit,
  output logic                 warn
);
  logic          open_q, wpol_q, clean_q;
  logic [DW-1:0] mag;
  logic          below, xing, same;

  always_comb begin
    mag     = sample[DW-1] ? $unsigned(~sample + 1'b1) : $unsigned(sample);
    below   = mag < thr;
    xing    = pos_x | neg_x;
    same    = open_q & (pos_x ? wpol_q : ~wpol_q);
    sag_hit = xing & same & clean_q & below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      wpol_q  <= 1'b0;
      clean_q <= 1'b0;
      warn    <= 1'b0;
    end else if (vld) begin
      if (xing && (!open_q || same)) begin
        open_q  <= 1'b1;
        wpol_q  <= pos_x;
        clean_q <= below;
      end else if (open_q) begin
        clean_q <= clean_q & below;
      end
      if (sag_hit)     warn <= 1'b1;
      else if (!below) warn <= 1'b0;
    end
  end
endmodule

// File: rtl/zcs_pulse.sv
// Retriggerable fixed-width pulse stretcher.
module zcs_pulse #(
  parameter int PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(PW + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= CW'(PW);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse = cnt != '0;
endmodule

// File: rtl/zcs_status.sv
// Sticky event bits; a set beats a clear in the same cycle.
module zcs_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (set[i]) q <= 1'b1;
      else if (clr[i]) q <= 1'b0;
    end
    assign sts[i] = q;
  end
endmodule

// File: rtl/zcs_detector.sv
module zcs_detector
  import zcs_pkg::*;
#(
  parameter int DW      = 16,
  parameter int HYST    = 64,
  parameter int PULSE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [DW-1:0]   smp_data,
  input  logic [1:0]      zx_mode,
  input  logic [DW-1:0]   sag_thr,
  input  logic [ST_W-1:0] sts_clr,
  output logic            zx_out,
  output logic            sag_warn,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic                 take;
  logic signed [DW-1:0] smp_s;
  logic                 pos_x, neg_x, sag_hit, zx_sel;
  logic [ST_W-1:0]      ev;
  zx_mode_e             mode;

  assign smp_ready = 1'b1;
  assign take      = smp_valid & smp_ready;
  assign smp_s     = $signed(smp_data);
  assign mode      = zx_mode_e'(zx_mode);

  zcs_edge #(.DW(DW), .HYST(HYST)) edge_i (
    .clk(clk), .rst_n(rst_n), .vld(take), .sample(smp_s),
    .pos_x(pos_x), .neg_x(neg_x)
  );

  zcs_sag #(.DW(DW)) sag_i (
    .clk(clk), .rst_n(rst_n), .vld(take), .sample(smp_s), .thr(sag_thr),
    .pos_x(pos_x), .neg_x(neg_x), .sag_hit(sag_hit), .warn(sag_warn)
  );

  always_comb begin
    zx_sel     = (pos_x & (mode != ZX_NEG)) | (neg_x & (mode != ZX_POS));
    ev         = '0;
    ev[ST_SAG] = sag_hit;
    ev[ST_ZX]  = zx_sel;
  end

  zcs_pulse #(.PW(PULSE_W)) pulse_i (
    .clk(clk), .rst_n(rst_n), .trig(zx_sel), .pulse(zx_out)
  );

  zcs_status #(.N(ST_W)) status_i (
    .clk(clk), .rst_n(rst_n), .set(ev), .clr(sts_clr), .sts(status)
  );

  assign irq = |status;
endmodule

// File: rtl/zcs_detector_chk.sv
module zcs_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_valid,
  input logic       smp_ready,
  input logic [1:0] sts_clr,
  input logic       zx_out,
  input logic       sag_warn,
  input logic [1:0] status
);
  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_ready);

  // R5
  zx_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !zx_out) |=> !zx_out);

  // R8
  warn_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sag_warn) |-> status[0]);

  // R9
  sag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !sts_clr[0]) |=> status[0]);

  // R9
  zx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !sts_clr[1]) |=> status[1]);

  // R9
  zx_status_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !status[1]) |=> !status[1]);
endmodule

bind zcs_detector zcs_detector_chk chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .sts_clr(sts_clr), .zx_out(zx_out), .sag_warn(sag_warn), .status(status)
);

// File: tb/zcs_detector_tb_top.sv
module zcs_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int HYST = 64;
  localparam int PW   = 4;
  localparam int BASE [10] = '{5, 3, 1, -1, -3, -5, -3, -1, 1, 3};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [DW-1:0] smp_data = '0;
  logic [1:0]    zx_mode = 2'b10;
  logic [DW-1:0] sag_thr = 16'd1000;
  logic [1:0]    sts_clr = 2'b00;
  logic          zx_out, sag_warn, irq;
  logic [1:0]    status;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_known, m_pos, m_open, m_wpol, m_clean, m_warn, zx_prev;
  bit [1:0] m_sts;
  int m_cnt, rises;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcs_detector #(.DW(DW), .HYST(HYST), .PULSE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .zx_mode(zx_mode), .sag_thr(sag_thr), .sts_clr(sts_clr),
    .zx_out(zx_out), .sag_warn(sag_warn), .status(status), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pat(int i, int k);
    return BASE[i % 10] * k;
  endfunction

  function automatic int tri_wave(int ph, int per, int amp);
    int q, half;
    half = per / 2;
    q = ph % per;
    if (q < half) return amp - (2 * amp * q) / half;
    return -amp + (2 * amp * (q - half)) / (per - half);
  endfunction

  // Bench model of one clock edge, written from the requirements.
  task automatic model_edge(bit v, int s, bit [1:0] clr);
    bit hi, lo, px, nx, below, same, sag, sel;
    bit [1:0] setv;
    int mag;
    hi = s >= HYST;                 // R2
    lo = s <= -HYST;
    px = v && m_known && !m_pos && hi;   // R3
    nx = v && m_known && m_pos && !hi && lo;
    mag = (s < 0) ? -s : s;
    below = mag < int'(sag_thr);
    same = m_open && (px ? m_wpol : !m_wpol);
    sag = (px || nx) && same && m_clean && below;              // R6
    sel = (px && zx_mode != 2'b01) || (nx && zx_mode != 2'b00); // R4
    if (v) begin
      if ((px || nx) && (!m_open || same)) begin
        m_open = 1; m_wpol = px; m_clean = below;
      end else if (m_open) m_clean = m_clean && below;          // R7
      if (hi) begin m_known = 1; m_pos = 1; end
      else if (lo) begin m_known = 1; m_pos = 0; end
      if (sag) m_warn = 1; else if (!below) m_warn = 0;
    end
    if (sel) m_cnt = PW; else if (m_cnt > 0) m_cnt--;
    setv = {sel, sag};
    for (int i = 0; i < 2; i++)
      m_sts[i] = setv[i] ? 1'b1 : (clr[i] ? 1'b0 : m_sts[i]);
  endtask

  task automatic step(bit v, int s, bit [1:0] clr);
    @(negedge clk);
    smp_valid = v; smp_data = 16'(s); sts_clr = clr;
    model_edge(v, s, clr);
    @(posedge clk); #1;
    chk("R5 zx_out", int'(zx_out), int'(m_cnt != 0));
    chk("R8 sag_warn", int'(sag_warn), int'(m_warn));
    chk("R9 status", int'(status), int'(m_sts));
    chk("R10 irq", int'(irq), int'(|m_sts));
    if (zx_out && !zx_prev) rises++;
    zx_prev = zx_out;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; smp_valid = 0; sts_clr = 0;
    m_known = 0; m_pos = 0; m_open = 0; m_wpol = 0; m_clean = 0; m_warn = 0;
    m_sts = 0; m_cnt = 0; zx_prev = 0; rises = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int amp, per, ph, s;
    bit v;
    bit [1:0] clr;
    void'($urandom(32'd4711));

    // R11 reset state, R1 ready
    do_reset();
    #1;
    chk("R11 zx_out", int'(zx_out), 0);
    chk("R11 sag_warn", int'(sag_warn), 0);
    chk("R11 status", int'(status), 0);
    chk("R11 irq", int'(irq), 0);
    chk("R1 ready", int'(smp_ready), 1);

    // R2 hysteresis band and first polarity, R3 crossing
    zx_mode = 2'b10;
    step(1, 30, 0);   chk("R2 in-band first sample", int'(zx_out), 0);
    step(1, 100, 0);  chk("R2 first polarity no crossing", int'(zx_out), 0);
    step(1, -30, 0);  chk("R2 in-band no crossing", int'(zx_out), 0);
    step(1, -100, 0); chk("R3 negative crossing", int'(zx_out), 1);
    repeat (5) step(0, 0, 0);
    step(1, 40, 0);   chk("R2 band upper", int'(zx_out), 0);
    step(1, 64, 0);   chk("R2 equal to +HYST crosses", int'(zx_out), 1);

    // R5 retrigger
    step(1, -100, 0);
    step(1, 100, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 0);
      chk("R5 retrigger width", int'(zx_out), (i < PW - 1) ? 1 : 0);
    end

    // R4 mode selection
    for (int m = 0; m < 4; m++) begin
      do_reset();
      zx_mode = 2'(m); sag_thr = 16'd1000;
      for (int i = 0; i < 30; i++) step(1, pat(i, 600), 0);
      repeat (6) step(0, 0, 0);
      chk("R4 crossing count per mode", rises, (m < 2) ? 3 : 6);
    end

    // R6 sag after one full period, R8, R9, R10
    do_reset();
    zx_mode = 2'b10; sag_thr = 16'd1000;
    for (int i = 0; i < 14; i++) begin
      step(1, pat(i, 100), 0);
      if (i == 12) chk("R6 no sag before period end", int'(sag_warn), 0);
    end
    chk("R6 sag at full period", int'(sag_warn), 1);
    chk("R9 sag status set", int'(status[0]), 1);
    chk("R10 irq with status", int'(irq), 1);
    step(1, 2000, 0);
    chk("R8 warn released by large sample", int'(sag_warn), 0);
    chk("R9 sag status sticky", int'(status[0]), 1);
    step(0, 0, 2'b01);
    chk("R9 sag bit cleared", int'(status[0]), 0);
    chk("R9 crossing bit kept", int'(status[1]), 1);
    step(0, 0, 2'b10);
    chk("R10 irq low with no status", int'(irq), 0);

    // R7 spike cancels a window
    do_reset();
    for (int i = 0; i < 24; i++) begin
      step(1, (i == 7) ? -1500 : pat(i, 100), 0);
      if (i == 13) chk("R7 spiked window no sag", int'(sag_warn), 0);
      if (i == 22) chk("R7 next window pending", int'(sag_warn), 0);
    end
    chk("R7 next window sags", int'(sag_warn), 1);

    // R7 peaks equal to the threshold never sag
    do_reset();
    sag_thr = 16'd500;
    for (int i = 0; i < 40; i++) step(1, pat(i, 100), 0);
    chk("R7 equal-threshold no sag", int'(status[0]), 0);

    // random stream checked against the model
    do_reset();
    ph = 0;
    for (int b = 0; b < 100; b++) begin
      amp = int'($urandom_range(4000, 0));
      per = int'($urandom_range(40, 8));
      zx_mode = 2'($urandom_range(3, 0));
      sag_thr = 16'($urandom_range(3000, 200));
      for (int j = 0; j < 200; j++) begin
        v = $urandom_range(99, 0) < 85;
        s = tri_wave(ph, per, amp) + int'($urandom_range(100, 0)) - 50;
        if (v) ph++;
        clr = ($urandom_range(99, 0) < 5) ? 2'($urandom_range(3, 0)) : 2'b00;
        step(v, s, clr);
      end
    end
    chk("R1 ready after stream", int'(smp_ready), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule